// File: doc/BRIEF.md
# Readout Dot Timing Generator

This block produces the timed control signals for one readout dot. A strobe from the start governor clears an internal chain of fill stages and arms a control flop. After the strobe is released, a periodic tick enable (nominally 5 MHz, one clock wide) pushes a one into the chain on every tick. Each output is decoded from the point where the ones have reached. The beam is unblanked while the fill sits between the third and fifth stages. A one-clock fetch pulse asks for the next byte of dot data when the sixth stage fills. A completion flag rises once the whole chain is full, and the start governor watches that flag before it issues the next strobe.

The control flop takes the readout-active level on every tick. If readout control is withdrawn partway through a dot, the beam is blanked again at the next tick. The whole design runs on one synchronous clock. The tick input is a clock enable, not a clock.

Top module: `dot_cycle_gen`

## Requirements
- R1: In any clock where `start_n` is sampled low, every fill stage is cleared and the control flop is set high. In the next cycle `rest`, `unblank` and `get_dot` are all low.
- R2: While `start_n` is high, each clock with `tick` high fills exactly one more stage, and a clock without `tick` leaves the fill count unchanged. A `tick` that coincides with `start_n` low has no effect.
- R3: `unblank` goes high in the cycle after the tick that fills the third stage, provided the control flop is high.
- R4: `unblank` goes low in the cycle after the tick that fills the fifth stage. Once the chain is full it stays low.
- R5: The control flop takes the `ro_active` level at every tick while `start_n` is high. While the control flop is low, `unblank` is low.
- R6: `get_dot` is high for exactly one clock: the cycle after the tick that fills the sixth stage. It does not repeat while the chain stays full.
- R7: `rest` is low from the start strobe until the tick that fills the eighth (last) stage. It is high from the next cycle onward and stays high until the next start strobe.
- R8: A clock with `rst_n` low puts the chain in the full state and the control flop low. After it, `rest` is high and `unblank` and `get_dot` are low.
- R9: A start strobe that arrives while a dot is in progress restarts the timing from an empty chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_n | input | 1 | Active-low start-dot strobe |
| tick | input | 1 | Dot timer tick enable, one clock wide |
| ro_active | input | 1 | Readout-active level (high = readout owns the display) |
| unblank | output | 1 | Beam unblank for the dot |
| get_dot | output | 1 | One-clock request for the next dot data byte |
| rest | output | 1 | Dot cycle complete; ready for the next start |

## Verification
Two cases are hard to reach from the ports. The first is a start strobe that lands in every possible fill position. The second is readout control dropping at a chosen tick inside the unblank window, with irregular tick spacing. The bench covers both with nested sweeps. It varies the gap between ticks, the tick count at which a second strobe restarts the cycle (in each sweep that strobe also carries a coincident tick), and the tick at which `ro_active` falls. After every clock it compares the outputs with a tick-count model.

// File: rtl/dotgen_pkg.sv
// Package: default geometry of the dot timing chain.
// Stage numbers are 1-based. Stage k is full after k ticks.
package dotgen_pkg;
    localparam int DG_STAGES      = 8;  // length of the fill chain
    localparam int DG_UNBLANK_ON  = 3;  // stage whose filling opens the beam
    localparam int DG_UNBLANK_OFF = 5;  // stage whose filling closes the beam
    localparam int DG_FETCH       = 6;  // stage whose filling requests data
endpackage

// File: rtl/dot_stage_chain.sv
// Module: dot_stage_chain
// A chain of one-bit stages that fills with ones from stage 0 upward.
// Assumes: clear has priority over advance. Reset leaves the chain full,
// which means idle.
module dot_stage_chain #(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [STAGES-1:0] fill
);
    logic [STAGES-1:0] next_in;

    // Purpose: the value each stage takes on advance (a one at the bottom).
    assign next_in = {fill[STAGES-2:0], 1'b1};

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic q;
        // Purpose: one stage of the chain: reset full, clear empty, shift on tick.
        always_ff @(posedge clk) begin
            if (!rst_n)       q <= 1'b1;
            else if (clear)   q <= 1'b0;
            else if (advance) q <= next_in[i];
        end
        assign fill[i] = q;
    end

    // The chain is always a thermometer code.
    assert_thermometer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill & ~next_in) == '0);
    // A clear empties the whole chain in one clock.
    assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fill == '0));
    // With no tick and no clear, the chain holds.
    assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !advance) |=> $stable(fill));
endmodule

// File: rtl/dot_ctrl_flop.sv
// Module: dot_ctrl_flop
// Control flop. It is set by the start strobe and then takes the
// readout-active level at each tick.
// Assumes: clear and advance come from the same strobe/tick decode as the chain.
module dot_ctrl_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    input  logic ro_active,
    output logic ctrl
);
    // Purpose: set on start, then follow readout-active at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= 1'b0;
        else if (clear)   ctrl <= 1'b1;
        else if (advance) ctrl <= ro_active;
    end

    assert_start_sets_ctrl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> ctrl);
    assert_ctrl_follows_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear) |=> (ctrl == $past(ro_active)));
endmodule

// File: rtl/dot_output_decode.sv
// Module: dot_output_decode
// Decodes the beam window, the data-fetch pulse and the completion flag
// from chosen stages of the chain.
// Assumes: fill is a thermometer code, and ON < OFF <= STAGES, FETCH <= STAGES.
module dot_output_decode #(
    parameter int STAGES = 8,
    parameter int ON     = 3,
    parameter int OFF    = 5,
    parameter int FETCH  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] fill,
    input  logic              ctrl,
    output logic              unblank,
    output logic              get_dot,
    output logic              rest
);
    localparam int ON_IX    = ON - 1;
    localparam int OFF_IX   = OFF - 1;
    localparam int FETCH_IX = FETCH - 1;
    localparam int LAST_IX  = STAGES - 1;

    logic fetch_seen;

    // Purpose: remember the fetch stage from the last clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fetch_seen <= 1'b1;
        else        fetch_seen <= fill[FETCH_IX];
    end

    // Purpose: beam window, fetch edge and completion decode.
    always_comb begin
        unblank = fill[ON_IX] & ~fill[OFF_IX] & ctrl;
        get_dot = fill[FETCH_IX] & ~fetch_seen;
        rest    = fill[LAST_IX];
    end

    assert_fetch_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        get_dot |=> !get_dot);
    assert_beam_off_at_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rest |-> !unblank);
    assert_beam_needs_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl |-> !unblank);
endmodule

// File: rtl/dot_cycle_gen.sv
// Module: dot_cycle_gen (top)
// Timing generator for one readout dot. It is built from a fill chain, a
// control flop and an output decoder.
// Assumes: tick is a single-clock enable. start_n is synchronous to clk.
module dot_cycle_gen #(
    parameter int STAGES      = dotgen_pkg::DG_STAGES,
    parameter int UNBLANK_ON  = dotgen_pkg::DG_UNBLANK_ON,
    parameter int UNBLANK_OFF = dotgen_pkg::DG_UNBLANK_OFF,
    parameter int FETCH       = dotgen_pkg::DG_FETCH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_n,
    input  logic tick,
    input  logic ro_active,
    output logic unblank,
    output logic get_dot,
    output logic rest
);
    logic              clear;
    logic              advance;
    logic              ctrl;
    logic [STAGES-1:0] fill;

    // Purpose: the strobe clears, and a tick outside the strobe advances.
    assign clear   = ~start_n;
    assign advance = start_n & tick;

    dot_stage_chain #(.STAGES(STAGES)) u_chain (
        .clk(clk), .rst_n(rst_n), .clear(clear), .advance(advance), .fill(fill)
    );

    dot_ctrl_flop u_ctrl (
        .clk(clk), .rst_n(rst_n), .clear(clear), .advance(advance),
        .ro_active(ro_active), .ctrl(ctrl)
    );

    dot_output_decode #(
        .STAGES(STAGES), .ON(UNBLANK_ON), .OFF(UNBLANK_OFF), .FETCH(FETCH)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .fill(fill), .ctrl(ctrl),
        .unblank(unblank), .get_dot(get_dot), .rest(rest)
    );

    assert_start_drops_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_n |=> !rest);
    assert_rest_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rest && start_n) |=> rest);
    assert_start_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !start_n |=> (!unblank && !get_dot));
endmodule

// File: tb/sim_dot_cycle_gen.sv
module sim_dot_cycle_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_n = 1'b1;
    logic tick = 1'b0;
    logic ro_active = 1'b1;
    logic unblank, get_dot, rest;

    int checks = 0;
    int fails = 0;
    int n = 8;       // ticks since start, saturating at 8
    int nprev = 8;
    bit ctrl_m = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    dot_cycle_gen u0 (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .tick(tick),
        .ro_active(ro_active), .unblank(unblank), .get_dot(get_dot), .rest(rest)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (n=%0d)", tag, act, exp, n);
        end
    endtask

    // Apply one clock of stimulus, advance the model, then compare at the falling edge.
    task automatic step(input logic s, input logic t, input logic r);
        start_n = s; tick = t; ro_active = r;
        @(posedge clk);
        nprev = n;
        if (!s) begin
            n = 0; ctrl_m = 1'b1;              // R1 R9: tick during start ignored (R2)
        end else if (t) begin
            if (n < 8) n++;
            ctrl_m = r;                        // R5
        end
        @(negedge clk);
        chk("R2 R3 R4 R5 unblank", unblank, (n >= 3 && n < 5 && ctrl_m));
        chk("R6 get_dot", get_dot, (n >= 6 && nprev < 6));
        chk("R7 rest", rest, (n >= 8));
        if (!s) chk("R1 R9 post-start rest", rest, 1'b0);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        // R8: reset state
        chk("R8 rest after reset", rest, 1'b1);
        chk("R8 unblank after reset", unblank, 1'b0);
        chk("R8 get_dot after reset", get_dot, 1'b0);
        rst_n = 1'b1;
        step(1, 1, 1);   // ticks while idle: chain stays full
        for (int gap = 1; gap <= 4; gap++) begin
            for (int rs = 0; rs <= 9; rs++) begin
                for (int drop = 0; drop <= 9; drop++) begin
                    step(0, 1, 1);
                    for (int k = 0; k < 11; k++) begin
                        logic ra;
                        ra = (k < drop);
                        for (int g = 0; g < gap - 1; g++) step(1, 0, ra);
                        step(1, 1, ra);
                        if (k == rs) step(0, 1, ra);   // R9 restart mid-cycle
                    end
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule